// File: doc/BRIEF.md
# Fractional PLL coefficient calculator

This block works out the divider settings for a fractional-N frequency synthesizer. It is given the reference clock frequency and the wanted system-clock frequency, both as unsigned integers in hertz. From these it returns an integer feedback divider, a 22-bit fractional feedback divider, a flag that asks for a divide-by-two after the oscillator, and a flag that selects fractional mode. Firmware or a sequencer loads both frequencies, pulses `start`, and waits for the one-cycle `done` pulse before it copies the results into the synthesizer.

The oscillator has to run inside a fixed window of 90 MHz to 100 MHz, and a divide-by-four always sits on its output. The block therefore sets the oscillator target to four times the requested frequency, and doubles it when that is too low. It then divides the target by the reference. The integer part becomes N. The remainder is scaled up by ten times 2^22 and divided by the reference again. That scaled fraction is rounded half-up to 22 bits to give K.

A single restoring divider that makes one quotient bit per clock is shared by three successive divisions, so a calculation takes a fixed number of cycles. Two faults are reported rather than hidden: a target that lands outside the window raises a warning, and a zero reference ends the calculation at once with an error flag.

Top module: `pllc_calc`

## Requirements
- R1: The oscillator target is 4 × `out_hz`. When that product is below 90,000,000 the target is doubled and `post_div2` reads 1. Otherwise `post_div2` reads 0.
- R2: `range_warn` reads 1 exactly when the final target is below 90,000,000 or above 100,000,000. Both limits count as inside the window.
- R3: `n_div` equals floor(target / `ref_hz`), apart from the carry case of R5.
- R4: With rem = target mod `ref_hz` and S = floor(rem × 41,943,040 / `ref_hz`), `k_frac` is floor(S / 10), plus one when S mod 10 is 5 or more.
- R5: When the rounding of R4 reaches 2^22, `k_frac` reads 0 and `n_div` reads floor(target / `ref_hz`) + 1.
- R6: A start with `ref_hz` = 0 ends in a `done` pulse with `div_err` = 1 and `n_div` = `k_frac` = 0. `post_div2` and `range_warn` still follow R1 and R2. Any start with a non-zero reference clears `div_err`.
- R7: `frac_en` reads 1 exactly when `k_frac` is non-zero.
- R8: In the cycle after an accepted start, `busy` reads 1. It stays at 1 until the cycle in which `done` pulses high for one cycle, and in that cycle `busy` reads 0.
- R9: A start pulse while `busy` is 1 is ignored. The inputs are captured when a start is accepted, so later input changes do not affect the result.
- R10: The result outputs change only in the cycle in which `done` is high, and hold their values at all other times.
- R11: After reset, `busy`, `done` and every result output read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Starts a calculation when the block is idle |
| ref_hz | input | 32 | Reference frequency in Hz |
| out_hz | input | 32 | Wanted system-clock frequency in Hz |
| busy | output | 1 | A calculation is running |
| done | output | 1 | One-cycle pulse when the results update |
| n_div | output | 35 | Integer feedback divider |
| k_frac | output | 22 | Fractional feedback divider |
| frac_en | output | 1 | Fractional mode select (K non-zero) |
| post_div2 | output | 1 | Oscillator target was doubled; divide output by two |
| range_warn | output | 1 | Final target outside 90 to 100 MHz |
| div_err | output | 1 | Reference was zero |

## Verification
Two pairs of functions can land on the same result.

- **Rounding carry.** The rounding of the fraction can carry into the integer divider in the same completion cycle, so K wraps to zero while N is incremented. This is provoked with a 9,000,003 Hz reference and a 24,750,008 Hz request. The remainder there is one less than the reference, and the scaled fraction ends in a five. The result is judged on N = 11, K = 0 and fractional mode off.
- **Start during a run.** A new start can arrive while a calculation is still running. The bench pulses start with different inputs in the middle of a run and also changes the inputs after every accepted start. The result is then judged against the first request alone.

Bench functions model every outcome in 64-bit arithmetic. Both the directed window edges and random frequencies are checked against them.

// File: rtl/pllc_pkg.sv
// Package: shared state type for the PLL coefficient calculator.
// Assumes: nothing beyond IEEE 1800-2017.
package pllc_pkg;

    // Phases of one calculation; the divider is shared by the three DIV phases.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ZERO  = 3'd1,
        ST_DIV_N = 3'd2,
        ST_DIV_K = 3'd3,
        ST_DIV_R = 3'd4
    } pllc_state_e;

endpackage

// File: rtl/pllc_target.sv
// Module: pllc_target
// Forms the oscillator target from the requested output frequency: four
// times the request, doubled when that falls below the window floor. It also
// flags a final target outside the window.
// Assumes: TW >= FW + 3, so that eight times the request cannot overflow.
module pllc_target #(
    parameter int unsigned FW      = 32,
    parameter int unsigned TW      = FW + 3,
    parameter int unsigned VCO_MIN = 90_000_000,
    parameter int unsigned VCO_MAX = 100_000_000
) (
    input  logic [FW-1:0] out_hz,
    output logic [TW-1:0] target,
    output logic          post_div2,
    output logic          range_bad
);

    localparam logic [TW-1:0] LO = TW'(VCO_MIN);
    localparam logic [TW-1:0] HI = TW'(VCO_MAX);

    logic [TW-1:0] times4;

    // Scale the request, pick the doubling and check the window.
    always_comb begin
        times4    = TW'({out_hz, 2'b00});
        post_div2 = (times4 < LO);
        target    = post_div2 ? (times4 << 1) : times4;
        range_bad = (target < LO) || (target > HI);
    end

endmodule

// File: rtl/pllc_serdiv.sv
// Module: pllc_serdiv
// Restoring divider that makes one quotient bit per clock. A load pulse
// captures the dividend and divisor. After DW clocks the quotient and
// remainder are valid and done pulses for one cycle.
// Assumes: the divisor is non-zero. The caller filters out a zero divisor.
module pllc_serdiv #(
    parameter int unsigned DW = 60,
    parameter int unsigned VW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] dividend,
    input  logic [VW-1:0] divisor,
    output logic [DW-1:0] quotient,
    output logic [VW-1:0] remainder,
    output logic          done
);

    localparam int unsigned CW = $clog2(DW + 1);

    logic [DW-1:0] q_r;
    logic [VW-1:0] r_r;
    logic [VW-1:0] dvs_r;
    logic [CW-1:0] cnt_r;
    logic          run_r;
    logic          done_r;
    logic [VW:0]   trial;
    logic          fits;

    // Partial remainder with the next dividend bit brought down.
    always_comb begin
        trial = {r_r, q_r[DW-1]};
        fits  = (trial >= {1'b0, dvs_r});
    end

    // One restoring step per clock; the quotient shifts in behind the dividend.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_r    <= '0;
            r_r    <= '0;
            dvs_r  <= '0;
            cnt_r  <= '0;
            run_r  <= 1'b0;
            done_r <= 1'b0;
        end else begin
            done_r <= 1'b0;
            if (load) begin
                q_r   <= dividend;
                r_r   <= '0;
                dvs_r <= divisor;
                cnt_r <= CW'(DW);
                run_r <= 1'b1;
            end else if (run_r) begin
                r_r   <= fits ? VW'(trial - {1'b0, dvs_r}) : trial[VW-1:0];
                q_r   <= {q_r[DW-2:0], fits};
                cnt_r <= cnt_r - 1'b1;
                if (cnt_r == CW'(1)) begin
                    run_r  <= 1'b0;
                    done_r <= 1'b1;
                end
            end
        end
    end

    assign quotient  = q_r;
    assign remainder = r_r;
    assign done      = done_r;

endmodule

// File: rtl/pllc_round.sv
// Module: pllc_round
// Takes the rounded fraction quotient. If rounding reached a full unit of
// the fraction field, it carries that unit into the integer divider and
// clears the fraction.
// Assumes: the rounded quotient is at most 2^KW.
module pllc_round #(
    parameter int unsigned PW = 60,
    parameter int unsigned TW = 35,
    parameter int unsigned KW = 22
) (
    input  logic [PW-1:0] q_rnd,
    input  logic [TW-1:0] n_in,
    output logic [TW-1:0] n_out,
    output logic [KW-1:0] k_out
);

    logic carry;

    // Detect overflow of the fraction field and fold it into N.
    always_comb begin
        carry = |(q_rnd >> KW);
        n_out = carry ? (n_in + 1'b1) : n_in;
        k_out = carry ? '0 : q_rnd[KW-1:0];
    end

endmodule

// File: rtl/pllc_calc.sv
// Module: pllc_calc (top)
// Sequences one coefficient calculation over a shared serial divider, in
// three passes:
//   1. target / ref gives N and the remainder.
//   2. remainder * SCALE * 2^KW / ref gives the scaled fraction.
//   3. (scaled fraction + SCALE/2) / SCALE gives K, rounded half-up.
// A zero reference skips the divider and reports an error.
// Assumes: PW is wide enough for remainder * SCALE * 2^KW.
module pllc_calc #(
    parameter int unsigned FW      = 32,
    parameter int unsigned KW      = 22,
    parameter int unsigned SCALE   = 10,
    parameter int unsigned VCO_MIN = 90_000_000,
    parameter int unsigned VCO_MAX = 100_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [FW-1:0]    ref_hz,
    input  logic [FW-1:0]    out_hz,
    output logic             busy,
    output logic             done,
    output logic [FW+2:0]    n_div,
    output logic [KW-1:0]    k_frac,
    output logic             frac_en,
    output logic             post_div2,
    output logic             range_warn,
    output logic             div_err
);

    import pllc_pkg::*;

    localparam int unsigned TW        = FW + 3;
    localparam int unsigned PW        = FW + KW + 6;
    localparam int unsigned ROUND_ADD = SCALE / 2;

    pllc_state_e   st;
    logic [FW-1:0] ref_q;
    logic          pd_q;
    logic          rb_q;
    logic [TW-1:0] n_q;

    logic [TW-1:0] tgt_w;
    logic          tgt_pd;
    logic          tgt_bad;

    logic          div_load;
    logic [PW-1:0] div_dvd;
    logic [FW-1:0] div_dvs;
    logic [PW-1:0] div_quo;
    logic [FW-1:0] div_rem;
    logic          div_done;

    logic [TW-1:0] rnd_n;
    logic [KW-1:0] rnd_k;

    pllc_target #(
        .FW(FW), .TW(TW), .VCO_MIN(VCO_MIN), .VCO_MAX(VCO_MAX)
    ) u_target (
        .out_hz    (out_hz),
        .target    (tgt_w),
        .post_div2 (tgt_pd),
        .range_bad (tgt_bad)
    );

    pllc_serdiv #(.DW(PW), .VW(FW)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (div_load),
        .dividend  (div_dvd),
        .divisor   (div_dvs),
        .quotient  (div_quo),
        .remainder (div_rem),
        .done      (div_done)
    );

    pllc_round #(.PW(PW), .TW(TW), .KW(KW)) u_round (
        .q_rnd (div_quo),
        .n_in  (n_q),
        .n_out (rnd_n),
        .k_out (rnd_k)
    );

    // Choose the operands and the load strobe for the next divider pass.
    always_comb begin
        div_load = 1'b0;
        div_dvd  = '0;
        div_dvs  = '0;
        unique case (st)
            ST_IDLE: begin
                div_dvd  = PW'(tgt_w);
                div_dvs  = ref_hz;
                div_load = start && (ref_hz != '0);
            end
            ST_DIV_N: begin
                div_dvd  = (PW'(div_rem) * PW'(SCALE)) << KW;
                div_dvs  = ref_q;
                div_load = div_done;
            end
            ST_DIV_K: begin
                div_dvd  = div_quo + PW'(ROUND_ADD);
                div_dvs  = FW'(SCALE);
                div_load = div_done;
            end
            default: begin
                div_dvd  = '0;
                div_dvs  = '0;
                div_load = 1'b0;
            end
        endcase
    end

    // Step through the passes and register the results on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            ref_q      <= '0;
            pd_q       <= 1'b0;
            rb_q       <= 1'b0;
            n_q        <= '0;
            done       <= 1'b0;
            n_div      <= '0;
            k_frac     <= '0;
            frac_en    <= 1'b0;
            post_div2  <= 1'b0;
            range_warn <= 1'b0;
            div_err    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        ref_q <= ref_hz;
                        pd_q  <= tgt_pd;
                        rb_q  <= tgt_bad;
                        st    <= (ref_hz == '0) ? ST_ZERO : ST_DIV_N;
                    end
                end
                ST_ZERO: begin
                    n_div      <= '0;
                    k_frac     <= '0;
                    frac_en    <= 1'b0;
                    div_err    <= 1'b1;
                    post_div2  <= pd_q;
                    range_warn <= rb_q;
                    done       <= 1'b1;
                    st         <= ST_IDLE;
                end
                ST_DIV_N: begin
                    if (div_done) begin
                        n_q <= div_quo[TW-1:0];
                        st  <= ST_DIV_K;
                    end
                end
                ST_DIV_K: begin
                    if (div_done) begin
                        st <= ST_DIV_R;
                    end
                end
                ST_DIV_R: begin
                    if (div_done) begin
                        n_div      <= rnd_n;
                        k_frac     <= rnd_k;
                        frac_en    <= (rnd_k != '0);
                        div_err    <= 1'b0;
                        post_div2  <= pd_q;
                        range_warn <= rb_q;
                        done       <= 1'b1;
                        st         <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy = (st != ST_IDLE);

endmodule

// File: rtl/pllc_calc_chk.sv
// Module: pllc_calc_chk
// Protocol and result checks for pllc_calc, attached to it with bind.
// Assumes: the same FW and KW as the instance it is bound to.
module pllc_calc_chk #(
    parameter int unsigned FW = 32,
    parameter int unsigned KW = 22
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic [FW+2:0] n_div,
    input logic [KW-1:0] k_frac,
    input logic          frac_en,
    input logic          div_err
);

    // R8: an accepted start makes busy high in the next cycle.
    a_r8_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R8: done lasts one cycle.
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: busy is low in the cycle in which done pulses.
    a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9: a start during a run neither ends it nor restarts it early.
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));

    // R6: a zero-reference result carries zero dividers.
    a_r6_zero_ref_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_err) |-> (n_div == '0 && k_frac == '0));

    // R7: the fractional-mode flag tracks a non-zero K.
    a_r7_frac_flag: assert property (@(posedge clk) disable iff (!rst_n)
        frac_en == (k_frac != '0));

    // R10: the results hold whenever done is low.
    a_r10_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(n_div) && $stable(k_frac) && $stable(div_err)));

endmodule

bind pllc_calc pllc_calc_chk #(.FW(FW), .KW(KW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .n_div   (n_div),
    .k_frac  (k_frac),
    .frac_en (frac_en),
    .div_err (div_err)
);

// File: tb/tb_pllc_calc.sv
module tb_pllc_calc;

    logic        clk;
    logic        rst_n;
    logic        start;
    logic [31:0] ref_hz;
    logic [31:0] out_hz;
    logic        busy;
    logic        done;
    logic [34:0] n_div;
    logic [21:0] k_frac;
    logic        frac_en;
    logic        post_div2;
    logic        range_warn;
    logic        div_err;

    int checks;
    int errors;
    bit finished;

    pllc_calc dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ref_hz(ref_hz), .out_hz(out_hz),
        .busy(busy), .done(done), .n_div(n_div), .k_frac(k_frac), .frac_en(frac_en),
        .post_div2(post_div2), .range_warn(range_warn), .div_err(div_err)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    // Expected results, from the requirements, in 64-bit arithmetic.
    task automatic model(input longint unsigned r, input longint unsigned o,
                         output longint unsigned en, output longint unsigned ek,
                         output bit epd, output bit ewarn, output bit eerr);
        longint unsigned tgt, rem, s;
        tgt = o * 4;
        epd = (tgt < 64'd90_000_000);
        if (epd) tgt = tgt * 2;
        ewarn = (tgt < 64'd90_000_000) || (tgt > 64'd100_000_000);
        if (r == 0) begin
            en = 0; ek = 0; eerr = 1'b1;
        end else begin
            eerr = 1'b0;
            en  = tgt / r;
            rem = tgt % r;
            s   = (rem * 64'd41_943_040) / r;
            ek  = s / 10;
            if ((s % 10) >= 5) ek = ek + 1;
            if (ek == 64'd4_194_304) begin
                ek = 0;
                en = en + 1;
            end
        end
    endtask

    task automatic chk(input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One calculation. An optional start during the run uses other inputs,
    // and the inputs are scrambled after the accepted start.
    task automatic run_calc(input logic [31:0] r, input logic [31:0] o,
                            input bit restart_mid);
        longint unsigned en, ek;
        bit epd, ewarn, eerr;
        int waitc;
        logic [34:0] n_hold;
        logic [21:0] k_hold;
        model(r, o, en, ek, epd, ewarn, eerr);
        @(negedge clk);
        ref_hz = r; out_hz = o; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        ref_hz = $urandom; out_hz = $urandom;    // R9: captured at start
        chk("R8", "busy after start", busy, 1);
        if (restart_mid && !done) begin
            @(negedge clk);
            ref_hz = 32'd7; out_hz = 32'd3_000_001; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        waitc = 0;
        while (!done && waitc < 1000) begin
            @(negedge clk);
            waitc++;
        end
        if (!done) begin
            chk("R8", "done timeout", 0, 1);
            return;
        end
        chk("R8", "busy low at done", busy, 0);
        chk("R3", "n_div", n_div, en);
        chk("R4", "k_frac", k_frac, ek);
        chk("R1", "post_div2", post_div2, epd);
        chk("R2", "range_warn", range_warn, ewarn);
        chk("R6", "div_err", div_err, eerr);
        chk("R7", "frac_en", frac_en, (ek != 0));
        n_hold = n_div; k_hold = k_frac;
        @(negedge clk);
        chk("R8", "done one cycle", done, 0);
        @(negedge clk);
        chk("R10", "n_div held", n_div, n_hold);
        chk("R10", "k_frac held", k_frac, k_hold);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150_000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed_val;
        checks = 0; errors = 0; finished = 1'b0;
        seed_val = $urandom(32'd20250611);
        rst_n = 1'b0; start = 1'b0; ref_hz = '0; out_hz = '0;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11", "busy", busy, 0);
        chk("R11", "done", done, 0);
        chk("R11", "n_div", n_div, 0);
        chk("R11", "k_frac", k_frac, 0);
        chk("R11", "flags", {frac_en, post_div2, range_warn, div_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_calc(32'd12_000_000, 32'd24_000_000, 1'b0);   // R3 exact ratio, K = 0
        run_calc(32'd12_000_000, 32'd12_288_000, 1'b0);   // R1 doubled target
        run_calc(32'd9_000_003,  32'd24_750_008, 1'b0);   // R5 rounding carry
        chk("R5", "carry N", n_div, 11);
        chk("R5", "carry K", k_frac, 0);
        run_calc(32'd0,          32'd24_000_000, 1'b0);   // R6 zero reference
        run_calc(32'd13_000_000, 32'd22_500_000, 1'b0);   // R2 lower edge 90 MHz
        run_calc(32'd13_000_000, 32'd25_000_000, 1'b0);   // R2 upper edge 100 MHz
        run_calc(32'd13_000_000, 32'd25_000_001, 1'b0);   // R2 just above
        run_calc(32'd13_000_000, 32'd22_499_999, 1'b0);   // R1/R2 doubled, too high
        run_calc(32'd13_000_000, 32'd10_000_000, 1'b0);   // R2 doubled, still low
        run_calc(32'd11_289_600, 32'd12_000_000, 1'b1);   // R9 start during a run
        run_calc(32'd1,          32'hFFFF_FFFF, 1'b0);    // R3 widest N

        for (int i = 0; i < 60; i++) begin
            logic [31:0] r, o;
            int unsigned mode;
            mode = $urandom_range(3, 0);
            case (mode)
                0: r = $urandom_range(30_000_000, 1);
                1: r = $urandom | 32'd1;
                2: r = $urandom_range(1000, 1);
                default: r = $urandom_range(27_000_000, 8_000_000);
            endcase
            if ($urandom_range(3, 0) == 0) o = $urandom;
            else o = $urandom_range(30_000_000, 5_000_000);
            run_calc(r, o, ($urandom_range(4, 0) == 0));   // R4 random fractions
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule